// File: doc/BRIEF.md
# Packet Deparser with Header Insert, Edit and Removal

This block rebuilds an outgoing packet at the end of a processing pipeline. It combines two inputs. The first is the original packet, which arrives as a stream of 64-bit beats. The second is a one-shot edit descriptor that the pipeline produces. The pipeline never rewrites header bytes in place. Instead it hands over a private copy of the edited header window, with a per-byte write mask. It also names one range of bytes to insert and one range to delete.

All edits are applied here, in one pass, in a fixed order:
1. Zero bytes are inserted at the requested offset.
2. The edited header bytes overwrite the stream. Positions are counted after the insertion, so a newly added header can be filled in.
3. Bytes in the removal range are marked dead in a per-byte keep mask.
4. A packer compacts the surviving bytes into dense output beats and moves the end-of-packet marker to the right beat.

A four-state machine sequences the work:
- **IDLE** waits for a descriptor. Transition *accept*: descriptor handshake, then go to BODY.
- **BODY** streams input beats. Transition *split*: the insertion offset falls inside the current beat, so the bytes before the offset are sent and the machine goes to INSERT without consuming the beat. Transition *end*: the beat marked last is consumed, then go to FLUSH.
- **INSERT** emits up to eight zero bytes per cycle. Transition *resume*: the zero run is complete, so return to BODY and send the rest of the held beat.
- **FLUSH** drains the packer. Transition *done*: the last output beat is taken, then return to IDLE.

Top module: `pkt_deparser`

## Requirements
- R1: `hdr_ready` is high only in IDLE. No input beat is accepted (`in_ready` low) until a descriptor has been taken.
- R2: A descriptor with `hdr_ins_len` = N > 0 inserts N zero bytes (N ≤ 63) before original byte `hdr_ins_off`. The offset must be below the original length.
- R3: Each output-stream position p below 16 with `hdr_wen[p]` set carries byte p of `hdr_bytes` (bits 8p+7:8p). Positions are counted after the insertion.
- R4: Bytes at positions `hdr_rm_off` up to `hdr_rm_off + hdr_rm_len - 1` are dropped. These positions are counted after the insertion.
- R5: Byte k of a beat sits in bits 8k+7:8k, with lower lanes first. Every output beat except the last has all eight `out_keep` bits set. The last beat's keep is a contiguous run from lane 0.
- R6: The output length equals the input length plus inserted bytes minus removed bytes. `out_last` marks exactly the beat holding the final byte.
- R7: With no insertion and `out_ready` held high, `in_ready` stays high on every cycle of the packet body.
- R8: While `out_valid` is high and `out_ready` is low, the output beat, keep and last stay unchanged on the next cycle.
- R9: After the last input beat is taken, `in_ready` stays low until the packet's final output beat is transferred. After that, the block is back in IDLE.
- R10: After reset, `hdr_ready` is 1, `in_ready` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Edit descriptor present |
| hdr_ready | output | 1 | Descriptor accepted (IDLE) |
| hdr_ins_off | input | 16 | Original byte offset for insertion |
| hdr_ins_len | input | 6 | Number of zero bytes to insert (0 = none) |
| hdr_rm_off | input | 16 | First removed position (after insertion) |
| hdr_rm_len | input | 6 | Number of removed bytes (0 = none) |
| hdr_bytes | input | 128 | Edited header window, byte p in bits 8p+7:8p |
| hdr_wen | input | 16 | Per-byte write mask for the header window |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 64 | Original packet bytes |
| in_keep | input | 8 | Valid lanes of the input beat |
| in_last | input | 1 | Final input beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 64 | Rebuilt packet bytes |
| out_keep | output | 8 | Valid lanes of the output beat |
| out_last | output | 1 | Final output beat |

## Verification
The checks compare the output against a byte-level model of the edits. The test packets are chosen so that each one isolates a different part of the datapath:
- A plain passthrough shows whether the packer sustains one beat per cycle.
- A merge-only packet tells masked header writes apart from unmasked ones.
- An insertion in mid-beat and one on a beat boundary that spans three cycles exercise both ways the machine splits a beat.
- A removal in the middle of a packet and one at its tail separate gap closing from moving the end marker to an earlier beat.
- A packet whose removal range overlaps freshly inserted bytes confirms the order insert, then merge, then remove.

Random output backpressure on several packets checks that stalled beats stay unchanged.

// File: rtl/deparse_pkg.sv
package deparse_pkg;

    typedef enum logic [1:0] {
        DP_IDLE,
        DP_BODY,
        DP_INSERT,
        DP_FLUSH
    } dp_state_e;

endpackage

// File: rtl/dp_edit.sv
module dp_edit #(
    parameter int BEAT_BYTES = 8,
    parameter int HDR_BYTES  = 16,
    parameter int POS_W      = 16,
    parameter int LEN_W      = 6
) (
    input  logic [BEAT_BYTES*8-1:0]            src_data,
    input  logic [BEAT_BYTES-1:0]              src_en,
    input  logic [BEAT_BYTES-1:0][POS_W-1:0]   src_pos,
    input  logic [HDR_BYTES*8-1:0]             hdr_bytes,
    input  logic [HDR_BYTES-1:0]               hdr_wen,
    input  logic [POS_W-1:0]                   rm_off,
    input  logic [LEN_W-1:0]                   rm_len,
    output logic [BEAT_BYTES*8-1:0]            ed_data,
    output logic [BEAT_BYTES-1:0]              ed_keep
);
    localparam int HIX_W = $clog2(HDR_BYTES);

    logic [POS_W:0] rm_end;
    assign rm_end = {1'b0, rm_off} + (POS_W+1)'(rm_len);

    for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_lane
        logic             in_win;
        logic             dead;
        logic [HIX_W-1:0] hix;
        assign hix    = src_pos[g][HIX_W-1:0];
        assign in_win = src_pos[g] < POS_W'(HDR_BYTES);
        assign dead   = (src_pos[g] >= rm_off) && ({1'b0, src_pos[g]} < rm_end);
        assign ed_data[g*8 +: 8] = (in_win && hdr_wen[hix]) ? hdr_bytes[{hix, 3'b000} +: 8]
                                                            : src_data[g*8 +: 8];
        assign ed_keep[g] = src_en[g] && !dead;
    end

endmodule

// File: rtl/dp_packer.sv
module dp_packer #(
    parameter int BEAT_BYTES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      app_valid,
    input  logic [BEAT_BYTES*8-1:0]   app_data,
    input  logic [BEAT_BYTES-1:0]     app_keep,
    input  logic                      flush,
    input  logic                      out_ready,
    output logic                      out_valid,
    output logic [BEAT_BYTES*8-1:0]   out_data,
    output logic [BEAT_BYTES-1:0]     out_keep,
    output logic                      out_last,
    output logic                      space_ok
);
    localparam int DATA_W = BEAT_BYTES * 8;
    localparam int ACC_B  = 2 * BEAT_BYTES;
    localparam int CNT_W  = $clog2(ACC_B + 1);

    logic [ACC_B*8-1:0] acc_q, acc_s, acc_d;
    logic [CNT_W-1:0]   cnt_q, cnt_s, cnt_d, take, run;
    logic               fire;

    always_comb begin
        take      = (cnt_q > CNT_W'(BEAT_BYTES)) ? CNT_W'(BEAT_BYTES) : cnt_q;
        out_valid = flush ? (cnt_q != '0) : (cnt_q > CNT_W'(BEAT_BYTES));
        out_last  = flush && (cnt_q <= CNT_W'(BEAT_BYTES));
        out_data  = acc_q[DATA_W-1:0];
        for (int j = 0; j < BEAT_BYTES; j++) begin
            out_keep[j] = CNT_W'(j) < take;
        end
        space_ok  = (cnt_q <= CNT_W'(BEAT_BYTES)) || out_ready;
    end

    always_comb begin
        fire  = out_valid && out_ready;
        acc_s = fire ? (acc_q >> DATA_W) : acc_q;
        cnt_s = fire ? (cnt_q - take) : cnt_q;
        acc_d = acc_s;
        run   = '0;
        for (int j = 0; j < BEAT_BYTES; j++) begin
            if (app_valid && app_keep[j]) begin
                acc_d[{cnt_s + run, 3'b000} +: 8] = app_data[j*8 +: 8];
                run = run + 1'b1;
            end
        end
        cnt_d = cnt_s + run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else begin
            acc_q <= acc_d;
            cnt_q <= cnt_d;
        end
    end

    // R5
    packed_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (&out_keep));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last)));

    // R6
    last_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> out_keep[0]);

endmodule

// File: rtl/pkt_deparser.sv
module pkt_deparser
    import deparse_pkg::*;
#(
    parameter int BEAT_BYTES = 8,
    parameter int HDR_BYTES  = 16,
    parameter int POS_W      = 16,
    parameter int LEN_W      = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hdr_valid,
    output logic                      hdr_ready,
    input  logic [POS_W-1:0]          hdr_ins_off,
    input  logic [LEN_W-1:0]          hdr_ins_len,
    input  logic [POS_W-1:0]          hdr_rm_off,
    input  logic [LEN_W-1:0]          hdr_rm_len,
    input  logic [HDR_BYTES*8-1:0]    hdr_bytes,
    input  logic [HDR_BYTES-1:0]      hdr_wen,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [BEAT_BYTES*8-1:0]   in_data,
    input  logic [BEAT_BYTES-1:0]     in_keep,
    input  logic                      in_last,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [BEAT_BYTES*8-1:0]   out_data,
    output logic [BEAT_BYTES-1:0]     out_keep,
    output logic                      out_last
);
    localparam int DATA_W = BEAT_BYTES * 8;
    localparam int LANE_W = $clog2(BEAT_BYTES);

    dp_state_e            state_q, state_d;
    logic [POS_W-1:0]     ob_q, ob_d, beat_end;
    logic [LANE_W-1:0]    lane_lo_q, lane_lo_d, cut_lane;
    logic [LEN_W-1:0]     ins_done_q, ins_done_d, ins_left;
    logic                 ins_pend_q, ins_pend_d, split;

    logic [POS_W-1:0]     d_ins_off, d_rm_off;
    logic [LEN_W-1:0]     d_ins_len, d_rm_len;
    logic [HDR_BYTES*8-1:0] d_hdr;
    logic [HDR_BYTES-1:0] d_wen;

    logic                 src_go, flush, pk_space;
    logic [BEAT_BYTES-1:0] src_mask, ed_keep;
    logic [DATA_W-1:0]    src_data, ed_data;
    logic [BEAT_BYTES-1:0][POS_W-1:0] src_pos;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= DP_IDLE;
            ob_q       <= '0;
            lane_lo_q  <= '0;
            ins_done_q <= '0;
            ins_pend_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            ob_q       <= ob_d;
            lane_lo_q  <= lane_lo_d;
            ins_done_q <= ins_done_d;
            ins_pend_q <= ins_pend_d;
        end
    end

    // descriptor capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_ins_off <= '0;
            d_ins_len <= '0;
            d_rm_off  <= '0;
            d_rm_len  <= '0;
            d_hdr     <= '0;
            d_wen     <= '0;
        end else if (hdr_valid && hdr_ready) begin
            d_ins_off <= hdr_ins_off;
            d_ins_len <= hdr_ins_len;
            d_rm_off  <= hdr_rm_off;
            d_rm_len  <= hdr_rm_len;
            d_hdr     <= hdr_bytes;
            d_wen     <= hdr_wen;
        end
    end

    // outputs and lane source
    always_comb begin
        beat_end  = ob_q + POS_W'(BEAT_BYTES);
        ins_left  = d_ins_len - ins_done_q;
        cut_lane  = d_ins_off[LANE_W-1:0];
        split     = ins_pend_q && (d_ins_off < beat_end);
        hdr_ready = 1'b0;
        in_ready  = 1'b0;
        flush     = 1'b0;
        src_go    = 1'b0;
        src_mask  = '0;
        src_data  = in_data;
        src_pos   = '0;
        unique case (state_q)
            DP_IDLE: hdr_ready = 1'b1;
            DP_BODY: begin
                in_ready = pk_space && !split;
                src_go   = in_valid && pk_space;
                for (int j = 0; j < BEAT_BYTES; j++) begin
                    src_mask[j] = in_keep[j] && (LANE_W'(j) >= lane_lo_q)
                                  && (!split || (LANE_W'(j) < cut_lane));
                    src_pos[j]  = ((ob_q + POS_W'(j)) >= d_ins_off)
                                  ? ob_q + POS_W'(j) + POS_W'(d_ins_len)
                                  : ob_q + POS_W'(j);
                end
            end
            DP_INSERT: begin
                src_go   = pk_space;
                src_data = '0;
                for (int j = 0; j < BEAT_BYTES; j++) begin
                    src_mask[j] = LEN_W'(j) < ins_left;
                    src_pos[j]  = d_ins_off + POS_W'(ins_done_q) + POS_W'(j);
                end
            end
            DP_FLUSH: flush = 1'b1;
        endcase
    end

    // next state
    always_comb begin
        state_d    = state_q;
        ob_d       = ob_q;
        lane_lo_d  = lane_lo_q;
        ins_done_d = ins_done_q;
        ins_pend_d = ins_pend_q;
        unique case (state_q)
            DP_IDLE: if (hdr_valid) begin
                state_d    = DP_BODY;
                ob_d       = '0;
                lane_lo_d  = '0;
                ins_done_d = '0;
                ins_pend_d = hdr_ins_len != '0;
            end
            DP_BODY: if (in_valid && pk_space) begin
                if (split) begin
                    state_d = DP_INSERT;
                end else begin
                    ob_d      = beat_end;
                    lane_lo_d = '0;
                    if (in_last) state_d = DP_FLUSH;
                end
            end
            DP_INSERT: if (pk_space) begin
                if (ins_left <= LEN_W'(BEAT_BYTES)) begin
                    ins_pend_d = 1'b0;
                    lane_lo_d  = cut_lane;
                    state_d    = DP_BODY;
                end else begin
                    ins_done_d = ins_done_q + LEN_W'(BEAT_BYTES);
                end
            end
            DP_FLUSH: if (out_valid && out_ready && out_last) state_d = DP_IDLE;
        endcase
    end

    dp_edit #(
        .BEAT_BYTES(BEAT_BYTES), .HDR_BYTES(HDR_BYTES), .POS_W(POS_W), .LEN_W(LEN_W)
    ) i_edit (
        .src_data (src_data),
        .src_en   (src_mask),
        .src_pos  (src_pos),
        .hdr_bytes(d_hdr),
        .hdr_wen  (d_wen),
        .rm_off   (d_rm_off),
        .rm_len   (d_rm_len),
        .ed_data  (ed_data),
        .ed_keep  (ed_keep)
    );

    dp_packer #(.BEAT_BYTES(BEAT_BYTES)) i_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .app_valid(src_go),
        .app_data (ed_data),
        .app_keep (ed_keep),
        .flush    (flush),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_keep (out_keep),
        .out_last (out_last),
        .space_ok (pk_space)
    );

    // R1
    one_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> !hdr_ready);

    // R1
    no_beat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ready |-> !in_ready);

    // R9
    input_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R9
    back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> hdr_ready);

endmodule

// File: tb/test_pkt_deparser.sv
module test_pkt_deparser;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hdr_valid = 1'b0;
    logic         hdr_ready;
    logic [15:0]  hdr_ins_off = '0;
    logic [5:0]   hdr_ins_len = '0;
    logic [15:0]  hdr_rm_off = '0;
    logic [5:0]   hdr_rm_len = '0;
    logic [127:0] hdr_bytes = '0;
    logic [15:0]  hdr_wen = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [63:0]  in_data = '0;
    logic [7:0]   in_keep = '0;
    logic         in_last = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [63:0]  out_data;
    logic [7:0]   out_keep;
    logic         out_last;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    pkt_deparser i_pkt_deparser (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_ins_off(hdr_ins_off), .hdr_ins_len(hdr_ins_len),
        .hdr_rm_off(hdr_rm_off), .hdr_rm_len(hdr_rm_len),
        .hdr_bytes(hdr_bytes), .hdr_wen(hdr_wen),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_keep(in_keep), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        check("R10", "hdr_ready after reset", int'(hdr_ready), 1);
        check("R10", "in_ready after reset", int'(in_ready), 0);
        check("R10", "out_valid after reset", int'(out_valid), 0);
        in_valid = 1'b1;
        in_keep  = 8'hFF;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            #1;
            check("R1", "in_ready without descriptor", int'(in_ready), 0);
        end
        in_valid = 1'b0;
    endtask

    task automatic run_pkt(input string name, input string req, input int len,
                           input int ins_off, input int ins_len,
                           input int rm_off, input int rm_len,
                           input logic [15:0] wen, input bit bp, input bit chk_tp);
        logic [7:0] src[$];
        logic [7:0] exp_q[$];
        logic [7:0] got[$];
        int nb, stalls, late, hold_err, unpacked, mism, cyc;
        bit done, prev_stall;
        logic [63:0] pdata;
        logic [7:0]  pkeep;
        nb = (len + 7) / 8;
        stalls = 0; late = 0; hold_err = 0; unpacked = 0; mism = 0; cyc = 0;
        done = 1'b0; prev_stall = 1'b0; pdata = '0; pkeep = '0;
        for (int i = 0; i < len; i++) src.push_back(8'(i * 13 + len * 3 + 5));
        for (int p = 0; p < len + ins_len; p++) begin
            logic [7:0] v;
            if (ins_len != 0 && p >= ins_off && p < ins_off + ins_len) v = 8'h00;
            else if (p < ins_off) v = src[p];
            else v = src[p - ins_len];
            if (p < 16 && wen[p]) v = 8'(8'hA0 + p);
            if (!(p >= rm_off && p < rm_off + rm_len)) exp_q.push_back(v);
        end
        fork
            begin : sender
                int b;
                b = 0;
                @(negedge clk);
                hdr_ins_off = 16'(ins_off);
                hdr_ins_len = 6'(ins_len);
                hdr_rm_off  = 16'(rm_off);
                hdr_rm_len  = 6'(rm_len);
                hdr_wen     = wen;
                for (int k = 0; k < 16; k++) hdr_bytes[k*8 +: 8] = 8'(8'hA0 + k);
                hdr_valid = 1'b1;
                #1;
                while (!hdr_ready) begin
                    @(negedge clk);
                    #1;
                end
                while (b < nb) begin
                    @(negedge clk);
                    hdr_valid = 1'b0;
                    for (int k = 0; k < 8; k++) begin
                        in_data[k*8 +: 8] = (b*8 + k < len) ? src[b*8 + k] : 8'h00;
                        in_keep[k]        = (b*8 + k < len);
                    end
                    in_last  = (b == nb - 1);
                    in_valid = 1'b1;
                    #1;
                    if (in_ready) b++;
                    else stalls++;
                end
                while (!done) begin
                    @(negedge clk);
                    #1;
                    if (in_ready && !done) late++;
                end
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            begin : receiver
                while (!done) begin
                    @(negedge clk);
                    out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
                    cyc++;
                    #1;
                    if (prev_stall && (!out_valid || out_data != pdata || out_keep != pkeep)) hold_err++;
                    prev_stall = out_valid && !out_ready;
                    pdata = out_data;
                    pkeep = out_keep;
                    if (out_valid && out_ready) begin
                        for (int k = 0; k < 8; k++)
                            if (out_keep[k]) got.push_back(out_data[k*8 +: 8]);
                        if (!out_last && out_keep != 8'hFF) unpacked++;
                        if (out_last && (((out_keep + 8'd1) & out_keep) != 8'h00)) unpacked++;
                        if (out_last) done = 1'b1;
                    end
                end
            end
        join
        out_ready = 1'b1;
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            if (got[i] != exp_q[i]) mism++;
        check(req, {name, " mismatched bytes"}, mism, 0);
        check("R6", {name, " output length"}, got.size(), exp_q.size());
        check("R5", {name, " packed beats"}, unpacked, 0);
        check("R9", {name, " in_ready after last"}, late, 0);
        if (bp) check("R8", {name, " stalled beat changed"}, hold_err, 0);
        if (chk_tp) check("R7", {name, " input stalls"}, stalls, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        run_pkt("passthrough",   "R5", 40, 0, 0, 0, 0, 16'h0000, 1'b0, 1'b1);
        run_pkt("merge_only",    "R3", 21, 0, 0, 0, 0, 16'hF0F3, 1'b0, 1'b0);
        run_pkt("insert_mid",    "R2", 30, 5, 4, 0, 0, 16'h01E0, 1'b0, 1'b0);
        run_pkt("insert_edge",   "R2", 26, 8, 20, 0, 0, 16'h0000, 1'b1, 1'b0);
        run_pkt("remove_mid",    "R4", 40, 0, 0, 3, 14, 16'h0000, 1'b1, 1'b0);
        run_pkt("remove_tail",   "R6", 17, 0, 0, 9, 8, 16'h0000, 1'b0, 1'b0);
        run_pkt("insert_remove", "R4", 33, 14, 6, 12, 5, 16'hC000, 1'b1, 1'b0);
        run_pkt("merge_after_in","R3", 12, 2, 3, 0, 0, 16'h001C, 1'b0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule